// File: doc/BRIEF.md
# Maskable interrupt status controller

This block gathers sixteen event inputs into one status word and turns that word into a single active-low interrupt request. Each event input is a single-cycle pulse from a detector elsewhere on the chip. The pulse sets a sticky flag, and the flag stays set until the host clears it. The host also programs a mask of enable bits. Any flag that is set while its enable bit is set pulls the request line low.

A small register port gives the host three 16-bit addresses:

- **Mask (0x0A):** read/write enable bits.
- **Status view (0x0B):** returns the flags and leaves them unchanged.
- **Clearing view (0x0C):** returns the same flags and clears them on that access.

Flag index 6 is set when a reset sequence finishes. It can be read, but it can never raise the request. Flag index 4 does not latch at all: it shows the present level of a zero-crossing input. Flag index 15 is reserved.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask reads 0x0000 and `irq_n` is 1. On the first clock edge after `rst_n` rises, flag 6 becomes set, so the status view then reads 0x0040 (with `zx_level_i` low).
- R2: A one-cycle pulse on `evt_i[k]` sets flag k, for every k except 4 and 15. The flag then stays set with no further pulses.
- R3: A read at address 0x0B returns the flag word and changes no flag.
- R4: A read at address 0x0C returns the flag word as it was before the access. On that same clock edge it clears every latched flag.
- R5: An event pulse in the same cycle as a clearing read at 0x0C leaves its flag set after the read.
- R6: Status bit 4 always equals `zx_level_i`. `evt_i[4]` has no effect, and a clearing read does not drop bit 4 while `zx_level_i` is high.
- R7: Bit 15 reads 0 at 0x0A, 0x0B and 0x0C. It ignores `evt_i[15]` and any write.
- R8: A write at 0x0A loads `wr_data[14:0]` into the mask, including bit 6, which reads back as stored. Writes at 0x0B and 0x0C change nothing.
- R9: `irq_n` is registered. It goes low on the clock edge after the first cycle in which a set flag (other than 6 or 15) has its mask bit set. It returns to 1 on the edge after the cycle in which no such pair remains.
- R10: Flag 6 never drives `irq_n` low, even when mask bit 6 is 1.
- R11: A pulse on `evt_i[6]` also sets flag 6, which covers the end of a software-started reset.
- R12: `rd_data` is 0 when `rd_en` is low or when the address is not one of the three above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Single-cycle event pulses, one per flag |
| zx_level_i | input | 1 | Live zero-crossing level shown on bit 4 |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 16 | Read data, valid in the cycle of `rd_en` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands in the same cycle as a clearing read. The bench drives `rd_en` at 0x0C and a pulse on a different flag from one falling edge, so both are seen on the same rising edge. It then checks two things: the read returns only the older flag, and the status view afterwards shows only the new one. The one-cycle lag of the request line is checked on the falling edges on both sides of the edge where it must change, both when a flag is set and when a clearing read removes it.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   typedef enum logic [1:0] {
      FLAG_STICKY = 2'd0,
      FLAG_LIVE   = 2'd1,
      FLAG_RSVD   = 2'd2
   } flag_kind_e;

   // Classify one flag position from the configured live and reserved indices.
   function automatic flag_kind_e kind_of(input int idx, input int live_idx, input int rsvd_idx);
      if (idx == rsvd_idx)      return FLAG_RSVD;
      else if (idx == live_idx) return FLAG_LIVE;
      else                      return FLAG_STICKY;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
   import irq_stat_pkg::*;
#(
   parameter int N_FLAGS  = 16,
   parameter int LIVE_BIT = 4,
   parameter int RSVD_BIT = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] set_i,
   input  logic               clr_i,
   input  logic               live_i,
   output logic [N_FLAGS-1:0] flags_o
);

   for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
      localparam flag_kind_e KIND = kind_of(g, LIVE_BIT, RSVD_BIT);
      if (KIND == FLAG_RSVD) begin : g_rsvd
         assign flags_o[g] = 1'b0;
      end else if (KIND == FLAG_LIVE) begin : g_live
         assign flags_o[g] = live_i;
      end else begin : g_sticky
         logic q;
         // a new event outranks a clear in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[g]) q <= 1'b1;
            else if (clr_i)    q <= 1'b0;
         end
         assign flags_o[g] = q;
      end
   end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
   parameter int                N_FLAGS  = 16,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] A_MASK   = 8'h0A,
   parameter logic [ADDR_W-1:0] A_VIEW   = 8'h0B,
   parameter logic [ADDR_W-1:0] A_CLR    = 8'h0C,
   parameter int                RSVD_BIT = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [N_FLAGS-1:0] wr_data,
   input  logic               rd_en,
   input  logic [N_FLAGS-1:0] flags_i,
   output logic [N_FLAGS-1:0] en_o,
   output logic [N_FLAGS-1:0] rd_data,
   output logic               clr_o
);

   localparam logic [N_FLAGS-1:0] ONE     = {{(N_FLAGS-1){1'b0}}, 1'b1};
   localparam logic [N_FLAGS-1:0] WR_MASK = ~(ONE << RSVD_BIT);

   logic [N_FLAGS-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         en_q <= '0;
      else if (wr_en && addr == A_MASK)   en_q <= wr_data & WR_MASK;
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (addr == A_MASK)                        rd_data = en_q;
         else if (addr == A_VIEW || addr == A_CLR)  rd_data = flags_i;
      end
   end

   assign clr_o = rd_en && (addr == A_CLR);
   assign en_o  = en_q;

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
   parameter int N_FLAGS  = 16,
   parameter int NOIRQ_BIT = 6,
   parameter int RSVD_BIT  = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] flags_i,
   input  logic [N_FLAGS-1:0] en_i,
   output logic               irq_n
);

   localparam logic [N_FLAGS-1:0] ONE      = {{(N_FLAGS-1){1'b0}}, 1'b1};
   localparam logic [N_FLAGS-1:0] IRQ_MASK = ~((ONE << NOIRQ_BIT) | (ONE << RSVD_BIT));

   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= |(flags_i & en_i & IRQ_MASK);
   end

   assign irq_n = ~req_q;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int                N_FLAGS   = 16,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] A_MASK    = 8'h0A,
   parameter logic [ADDR_W-1:0] A_VIEW    = 8'h0B,
   parameter logic [ADDR_W-1:0] A_CLR     = 8'h0C,
   parameter int                LIVE_BIT  = 4,
   parameter int                DONE_BIT  = 6,
   parameter int                RSVD_BIT  = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] evt_i,
   input  logic               zx_level_i,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [N_FLAGS-1:0] wr_data,
   input  logic               rd_en,
   output logic [N_FLAGS-1:0] rd_data,
   output logic               irq_n
);

   localparam logic [N_FLAGS-1:0] ONE = {{(N_FLAGS-1){1'b0}}, 1'b1};

   if (N_FLAGS < 2 || N_FLAGS > 32) begin : g_bad_width
      $error("irq_status_ctrl: N_FLAGS out of range");
   end
   if (LIVE_BIT >= N_FLAGS || DONE_BIT >= N_FLAGS || RSVD_BIT >= N_FLAGS) begin : g_bad_idx
      $error("irq_status_ctrl: special flag index outside word");
   end
   if (LIVE_BIT == DONE_BIT || LIVE_BIT == RSVD_BIT || DONE_BIT == RSVD_BIT) begin : g_dup_idx
      $error("irq_status_ctrl: special flag indices must differ");
   end
   if (A_MASK == A_VIEW || A_MASK == A_CLR || A_VIEW == A_CLR) begin : g_dup_addr
      $error("irq_status_ctrl: register addresses must differ");
   end

   logic               boot_q;
   logic [N_FLAGS-1:0] set_vec;
   logic [N_FLAGS-1:0] flags;
   logic [N_FLAGS-1:0] en_word;
   logic               clr;

   // one-shot after reset release marks the end of the hardware reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   assign set_vec = evt_i | (boot_q ? (ONE << DONE_BIT) : '0);

   irq_flag_bank #(
      .N_FLAGS (N_FLAGS),
      .LIVE_BIT(LIVE_BIT),
      .RSVD_BIT(RSVD_BIT)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr),
      .live_i (zx_level_i),
      .flags_o(flags)
   );

   irq_reg_port #(
      .N_FLAGS (N_FLAGS),
      .ADDR_W  (ADDR_W),
      .A_MASK  (A_MASK),
      .A_VIEW  (A_VIEW),
      .A_CLR   (A_CLR),
      .RSVD_BIT(RSVD_BIT)
   ) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .rd_en  (rd_en),
      .flags_i(flags),
      .en_o   (en_word),
      .rd_data(rd_data),
      .clr_o  (clr)
   );

   irq_req_gate #(
      .N_FLAGS  (N_FLAGS),
      .NOIRQ_BIT(DONE_BIT),
      .RSVD_BIT (RSVD_BIT)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags_i(flags),
      .en_i   (en_word),
      .irq_n  (irq_n)
   );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
   parameter int                N_FLAGS  = 16,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] A_MASK   = 8'h0A,
   parameter logic [ADDR_W-1:0] A_VIEW   = 8'h0B,
   parameter logic [ADDR_W-1:0] A_CLR    = 8'h0C,
   parameter int                LIVE_BIT = 4,
   parameter int                DONE_BIT = 6,
   parameter int                RSVD_BIT = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_FLAGS-1:0] evt_i,
   input logic               zx_level_i,
   input logic [ADDR_W-1:0]  addr,
   input logic               wr_en,
   input logic               rd_en,
   input logic [N_FLAGS-1:0] rd_data,
   input logic               irq_n,
   input logic [N_FLAGS-1:0] flags,
   input logic [N_FLAGS-1:0] en_word,
   input logic               boot_q
);

   localparam logic [N_FLAGS-1:0] ONE    = {{(N_FLAGS-1){1'b0}}, 1'b1};
   localparam logic [N_FLAGS-1:0] STICKY = ~((ONE << LIVE_BIT) | (ONE << RSVD_BIT));
   localparam logic [N_FLAGS-1:0] CAUSE  = ~((ONE << DONE_BIT) | (ONE << RSVD_BIT));

   // R2
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(evt_i & STICKY)) == $past(evt_i & STICKY)));

   // R4
   clear_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_CLR && evt_i == '0 && !boot_q) |=> ((flags & STICKY) == '0));

   // R6
   live_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[LIVE_BIT] == zx_level_i);

   // R7
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[RSVD_BIT] && !flags[RSVD_BIT] && !en_word[RSVD_BIT]);

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == A_VIEW || addr == A_CLR)) |=> $stable(en_word));

   // R9
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n == !(|($past(flags & en_word) & CAUSE))));

   // R12
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));

endmodule

bind irq_status_ctrl irq_status_chk #(
   .N_FLAGS (N_FLAGS),
   .ADDR_W  (ADDR_W),
   .A_MASK  (A_MASK),
   .A_VIEW  (A_VIEW),
   .A_CLR   (A_CLR),
   .LIVE_BIT(LIVE_BIT),
   .DONE_BIT(DONE_BIT),
   .RSVD_BIT(RSVD_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .zx_level_i(zx_level_i),
   .addr      (addr),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .rd_data   (rd_data),
   .irq_n     (irq_n),
   .flags     (flags),
   .en_word   (en_word),
   .boot_q    (boot_q)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt_i = '0;
   logic        zx_level_i = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        irq_n;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_status_ctrl i_irq_status_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .zx_level_i(zx_level_i),
      .addr      (addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .irq_n     (irq_n)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, sample combinational read data before the rising edge
   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #5 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0; addr = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wr_data = '0;
   endtask

   task automatic pulse(input logic [15:0] m);
      @(negedge clk);
      evt_i = m;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 irq_n idle", {15'd0, irq_n}, 16'h0001);
      rd(8'h0A, d); chk("R1 mask after reset", d, 16'h0000);
      rd(8'h0B, d); chk("R1 reset-done flag", d, 16'h0040);
      rd(8'h0C, d); chk("R4 clearing read value", d, 16'h0040);
      rd(8'h0B, d); chk("R4 cleared", d, 16'h0000);
      @(negedge clk); #5 chk("R12 idle read data", rd_data, 16'h0000);
      rd(8'h05, d); chk("R12 unmapped read", d, 16'h0000);
   endtask

   task automatic t_sticky();
      logic [15:0] d;
      pulse(16'h2001);
      repeat (3) @(negedge clk);
      rd(8'h0B, d); chk("R2 sticky flags", d, 16'h2001);
      rd(8'h0B, d); chk("R3 view does not clear", d, 16'h2001);
      rd(8'h0C, d); chk("R4 clearing read value", d, 16'h2001);
      rd(8'h0B, d); chk("R4 flags cleared", d, 16'h0000);
      pulse(16'h4880);
      rd(8'h0B, d); chk("R2 other flags", d, 16'h4880);
      rd(8'h0C, d);
   endtask

   task automatic t_live();
      logic [15:0] d;
      pulse(16'h0010);
      rd(8'h0B, d); chk("R6 event on live bit ignored", d, 16'h0000);
      @(negedge clk); zx_level_i = 1'b1;
      rd(8'h0B, d); chk("R6 live high", d, 16'h0010);
      rd(8'h0C, d); chk("R6 clearing read sees live", d, 16'h0010);
      rd(8'h0B, d); chk("R6 live survives clear", d, 16'h0010);
      @(negedge clk); zx_level_i = 1'b0;
      rd(8'h0B, d); chk("R6 live low", d, 16'h0000);
   endtask

   task automatic t_rsvd_mask();
      logic [15:0] d;
      pulse(16'h8000);
      rd(8'h0B, d); chk("R7 reserved event ignored", d, 16'h0000);
      wr(8'h0A, 16'hFFFF);
      rd(8'h0A, d); chk("R7 R8 mask write", d, 16'h7FFF);
      wr(8'h0B, 16'h0000);
      wr(8'h0C, 16'h1234);
      rd(8'h0A, d); chk("R8 writes to status ignored", d, 16'h7FFF);
      rd(8'h0B, d); chk("R8 status unchanged by write", d, 16'h0000);
      rd(8'h0C, d); chk("R7 clearing view bit 15", d, 16'h0000);
      wr(8'h0A, 16'h0000);
      rd(8'h0A, d); chk("R8 mask cleared", d, 16'h0000);
   endtask

   task automatic t_irq();
      logic [15:0] d;
      wr(8'h0A, 16'h0002);
      chk("R9 idle before event", {15'd0, irq_n}, 16'h0001);
      pulse(16'h0002);
      chk("R9 one clock lag", {15'd0, irq_n}, 16'h0001);
      @(negedge clk);
      chk("R9 asserted", {15'd0, irq_n}, 16'h0000);
      rd(8'h0C, d); chk("R4 irq flag read", d, 16'h0002);
      chk("R9 still low right after clear", {15'd0, irq_n}, 16'h0000);
      @(negedge clk);
      chk("R9 released", {15'd0, irq_n}, 16'h0001);
      pulse(16'h0001);
      repeat (2) @(negedge clk);
      chk("R9 masked flag no irq", {15'd0, irq_n}, 16'h0001);
      wr(8'h0A, 16'h0001);
      chk("R9 mask change lag", {15'd0, irq_n}, 16'h0001);
      @(negedge clk);
      chk("R9 asserted by mask", {15'd0, irq_n}, 16'h0000);
      wr(8'h0A, 16'h0000);
      @(negedge clk);
      chk("R9 released by mask", {15'd0, irq_n}, 16'h0001);
      rd(8'h0C, d);
   endtask

   task automatic t_done_flag();
      logic [15:0] d;
      wr(8'h0A, 16'h0040);
      rd(8'h0A, d); chk("R8 mask bit 6 stored", d, 16'h0040);
      pulse(16'h0040);
      rd(8'h0B, d); chk("R11 event sets flag 6", d, 16'h0040);
      repeat (2) @(negedge clk);
      chk("R10 flag 6 no irq", {15'd0, irq_n}, 16'h0001);
      rd(8'h0C, d);
      wr(8'h0A, 16'h0000);
   endtask

   task automatic t_coincide();
      logic [15:0] d;
      pulse(16'h0002);
      @(negedge clk);
      rd_en = 1'b1; addr = 8'h0C; evt_i = 16'h0004;
      #5 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0; addr = '0; evt_i = '0;
      chk("R5 read returns old flag", d, 16'h0002);
      rd(8'h0B, d); chk("R5 coincident event kept", d, 16'h0004);
      rd(8'h0C, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sticky();
      t_live();
      t_rsvd_mask();
      t_irq();
      t_done_flag();
      t_coincide();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule